// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block handles interrupt entry for a small single-address machine. Its memory words hold four 8-bit characters, and each character carries an odd-parity check bit. Character addresses are word addresses times four, so a character address that is a multiple of four selects the first character of a word. Instruction locations are given as character addresses. The vector location 4 is therefore word 1, and location 0 is word 0.

A request is formed by ANDing a set of condition latches with a programmable mask register and ORing the result. The request is taken only when the core signals that an instruction has completed. The block then stalls the core with `busy_o` and makes two character writes: the upper bits of the return word address go to character 1 and the low 8 bits go to character 2. In the third cycle it loads the program counter with the vector. A jump opcode kept at character 0 then reads characters 1 and 2 as its target, which gives the return path. Further entries are held off until the instruction at location 0 completes. The block also keeps a sticky flag that is set by any character read from memory with even parity.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o`, `pc_load_o` and `perr_o` are 0, and the mask register is all zeros, so every latch is masked.
- R2: The request is the OR over all bits of `latch_i & mask`. A latch whose mask bit is 0 never starts an entry. The mask register loads `mask_i` on the clock edge at which `mask_we_i` is 1.
- R3: An entry starts only on a clock edge at which `insn_done_i` is 1 and the request is active. A request with no completion strobe starts nothing.
- R4: In the first cycle after the accepting edge, `mem_we_o`=1 with `mem_addr_o`=1. The written character is the return word address shifted right by 8 and zero-extended to 8 bits, held in `mem_wdata_o[7:0]`. Its odd-parity bit is in `mem_wdata_o[8]`, so the 9 bits have an odd number of ones.
- R5: In the second cycle, `mem_we_o`=1 with `mem_addr_o`=2. The data is the low 8 bits of the return word address, with odd parity in bit 8.
- R6: In the third cycle, `pc_load_o`=1 and `pc_vec_o`=1, which is word 1, character location 4. `busy_o` is 1 for exactly these three cycles.
- R7: After an entry, no new entry starts until an instruction with `cur_pc_i`=0 completes. That completion itself does not start an entry. A request still active is taken at the next completion after it.
- R8: `perr_o` is set on the edge after a character read (`rd_valid_i`=1) whose 9 bits hold an even number of ones. It stays set until reset. A character with an odd count does not set it.
- R9: `mem_we_o` and `pc_load_o` are never 1 outside an entry sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_done_i | input | 1 | Instruction-complete strobe |
| cur_pc_i | input | 11 | Word address of the completing instruction |
| next_pc_i | input | 11 | Word address of the next instruction |
| latch_i | input | 8 | Condition latch inputs |
| mask_we_i | input | 1 | Mask register write enable |
| mask_i | input | 8 | Mask register write data |
| rd_valid_i | input | 1 | A character is read from memory this cycle |
| rd_char_i | input | 9 | Read character, parity in bit 8 |
| busy_o | output | 1 | Entry in progress; core stalls |
| mem_we_o | output | 1 | Character write strobe |
| mem_addr_o | output | 13 | Character write address |
| mem_wdata_o | output | 9 | Character write data, parity in bit 8 |
| pc_load_o | output | 1 | Load program counter with vector |
| pc_vec_o | output | 11 | Vector word address |
| perr_o | output | 1 | Sticky parity error flag |

## Verification
The return words 0x5A3, 0x123, 0x7FF and 0x000 exercise the split across the two characters. Between them they give a zero high character, a full high character and both parity polarities, which separates shift and truncation errors from parity-generation errors. Latch patterns that hit only masked bits, patterns that match the mask with no completion strobe, and strobes during the blocked window (including the location-0 completion itself) each show a different gating term failing. Any write or load the scoreboard did not expect is reported. Read characters with odd and even ones counts, given before and after an error, check that the flag sets and stays set.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_LOAD
  } ent_state_e;

  function automatic logic [8:0] add_odd_par(logic [7:0] c);
    return {~^c, c};
  endfunction

  function automatic logic char_par_ok(logic [8:0] c);
    return ^c;
  endfunction
endpackage

// File: rtl/irq_req.sv
module irq_req #(
  parameter int NLATCH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [NLATCH-1:0] mask_i,
  input  logic [NLATCH-1:0] latch_i,
  output logic              req_o
);
  logic [NLATCH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  assign req_o = |(latch_i & mask_q);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_entry_pkg::*;
#(
  parameter int WW       = 11,
  parameter int VEC_CHAR = 4,
  parameter int HI_LOC   = 1,
  parameter int LO_LOC   = 2,
  parameter int RET_WORD = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            insn_done_i,
  input  logic            req_i,
  input  logic [WW-1:0]   cur_pc_i,
  input  logic [WW-1:0]   next_pc_i,
  output logic            busy_o,
  output logic            mem_we_o,
  output logic [WW+1:0]   mem_addr_o,
  output logic [8:0]      mem_wdata_o,
  output logic            pc_load_o,
  output logic [WW-1:0]   pc_vec_o
);
  localparam int AW       = WW + 2;
  localparam int VEC_WORD = VEC_CHAR / 4;

  ent_state_e  state_q, state_d;
  logic [WW-1:0] ret_q;
  logic        blk_q;
  logic        take;

  assign take = insn_done_i && req_i && !blk_q && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take) state_d = ST_WR_HI;
      ST_WR_HI: state_d = ST_WR_LO;
      ST_WR_LO: state_d = ST_LOAD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ret_q   <= '0;
      blk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        ret_q <= next_pc_i;
        blk_q <= 1'b1;
      end else if (insn_done_i && blk_q && cur_pc_i == WW'(RET_WORD)) begin
        blk_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_WR_HI: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = AW'(HI_LOC);
        mem_wdata_o = add_odd_par(8'(ret_q >> 8));
      end
      ST_WR_LO: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = AW'(LO_LOC);
        mem_wdata_o = add_odd_par(ret_q[7:0]);
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign pc_load_o = (state_q == ST_LOAD);
  assign pc_vec_o  = WW'(VEC_WORD);
endmodule

// File: rtl/par_chk.sv
module par_chk
  import irq_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_valid_i,
  input  logic [8:0] rd_char_i,
  output logic       perr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    perr_o <= 1'b0;
    else if (rd_valid_i && !char_par_ok(rd_char_i)) perr_o <= 1'b1;
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int WW       = 11,
  parameter int NLATCH   = 8,
  parameter int VEC_CHAR = 4,
  parameter int HI_LOC   = 1,
  parameter int LO_LOC   = 2,
  parameter int RET_WORD = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_done_i,
  input  logic [WW-1:0]     cur_pc_i,
  input  logic [WW-1:0]     next_pc_i,
  input  logic [NLATCH-1:0] latch_i,
  input  logic              mask_we_i,
  input  logic [NLATCH-1:0] mask_i,
  input  logic              rd_valid_i,
  input  logic [8:0]        rd_char_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [WW+1:0]     mem_addr_o,
  output logic [8:0]        mem_wdata_o,
  output logic              pc_load_o,
  output logic [WW-1:0]     pc_vec_o,
  output logic              perr_o
);
  logic req;

  irq_req #(.NLATCH(NLATCH)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we_i),
    .mask_i    (mask_i),
    .latch_i   (latch_i),
    .req_o     (req)
  );

  irq_seq #(
    .WW(WW), .VEC_CHAR(VEC_CHAR), .HI_LOC(HI_LOC), .LO_LOC(LO_LOC), .RET_WORD(RET_WORD)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .insn_done_i (insn_done_i),
    .req_i       (req),
    .cur_pc_i    (cur_pc_i),
    .next_pc_i   (next_pc_i),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_load_o   (pc_load_o),
    .pc_vec_o    (pc_vec_o)
  );

  par_chk u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_valid_i (rd_valid_i),
    .rd_char_i  (rd_char_i),
    .perr_o     (perr_o)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int WW       = 11,
  parameter int VEC_CHAR = 4,
  parameter int HI_LOC   = 1,
  parameter int LO_LOC   = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          insn_done_i,
  input logic          busy_o,
  input logic          mem_we_o,
  input logic [WW+1:0] mem_addr_o,
  input logic [8:0]    mem_wdata_o,
  input logic          pc_load_o,
  input logic [WW-1:0] pc_vec_o,
  input logic          perr_o
);
  localparam int AW = WW + 2;

  p_start_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(insn_done_i));

  p_hi_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_we_o && mem_addr_o == AW'(HI_LOC)));

  p_wr_odd_par_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (^mem_wdata_o));

  p_lo_after_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == AW'(HI_LOC)) |=> (mem_we_o && mem_addr_o == AW'(LO_LOC)));

  p_load_after_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == AW'(LO_LOC)) |=> (pc_load_o && pc_vec_o == WW'(VEC_CHAR / 4)));

  p_load_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o);

  p_no_stray_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || pc_load_o) |-> busy_o);

  p_perr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |=> perr_o);
endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .WW(WW), .VEC_CHAR(VEC_CHAR), .HI_LOC(HI_LOC), .LO_LOC(LO_LOC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insn_done_i (insn_done_i),
  .busy_o      (busy_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .pc_load_o   (pc_load_o),
  .pc_vec_o    (pc_vec_o),
  .perr_o      (perr_o)
);

// File: tb/tb_irq_entry_ctrl.sv
module tb_irq_entry_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        insn_done = 0;
  logic [10:0] cur_pc = '0;
  logic [10:0] next_pc = '0;
  logic [7:0]  latch = '0;
  logic        mask_we = 0;
  logic [7:0]  mask = '0;
  logic        rd_valid = 0;
  logic [8:0]  rd_char = '0;
  logic        busy, mem_we, pc_load, perr;
  logic [12:0] mem_addr;
  logic [8:0]  mem_wdata;
  logic [10:0] pc_vec;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        ld;
    logic [12:0] addr;
    logic [8:0]  data;
  } ev_t;
  ev_t   exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_entry_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .insn_done_i(insn_done), .cur_pc_i(cur_pc),
    .next_pc_i(next_pc), .latch_i(latch), .mask_we_i(mask_we), .mask_i(mask),
    .rd_valid_i(rd_valid), .rd_char_i(rd_char), .busy_o(busy), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .pc_load_o(pc_load),
    .pc_vec_o(pc_vec), .perr_o(perr)
  );

  function automatic logic [8:0] odd9(logic [7:0] c);
    return {~^c, c};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic push_entry(logic [10:0] w);
    exp_q.push_back('{ld: 1'b0, addr: 13'd1, data: odd9(8'(w >> 8))}); tag_q.push_back("R4");
    exp_q.push_back('{ld: 1'b0, addr: 13'd2, data: odd9(w[7:0])});     tag_q.push_back("R5");
    exp_q.push_back('{ld: 1'b1, addr: 13'd0, data: 9'd0});             tag_q.push_back("R6");
  endtask

  task automatic boundary(logic [10:0] cur, logic [10:0] nxt);
    @(negedge clk); insn_done = 1; cur_pc = cur; next_pc = nxt;
    @(negedge clk); insn_done = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mask(logic [7:0] m);
    @(negedge clk); mask_we = 1; mask = m;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic rd(logic [8:0] c);
    @(negedge clk); rd_valid = 1; rd_char = c;
    @(negedge clk); rd_valid = 0;
  endtask

  // monitor: pop expected events as the design produces writes or loads
  always @(negedge clk) begin
    if (rst_n && (mem_we || pc_load)) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: unexpected event we=%0b ld=%0b addr=0x%0h expected none",
                 mem_we, pc_load, mem_addr);
      end else begin
        ev_t   e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e.ld) begin
          chk(t, {pc_load, mem_we}, 2'b10);
          chk(t, 32'(pc_vec), 32'd1);
        end else begin
          chk(t, {pc_load, mem_we}, 2'b01);
          chk(t, 32'(mem_addr), 32'(e.addr));
          chk(t, 32'(mem_wdata), 32'(e.data));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {busy, mem_we, pc_load, perr}, 4'b0000);

    // R2: reset mask blocks all latches
    latch = 8'hFF;
    boundary(11'h010, 11'h011);
    chk("R2", busy, 0);

    // R3: request without strobe does nothing
    set_mask(8'h04);
    latch = 8'h04;
    repeat (5) @(negedge clk);
    chk("R3", busy, 0);

    // R4 R5 R6: first entry
    push_entry(11'h5A3);
    @(negedge clk); insn_done = 1; cur_pc = 11'h100; next_pc = 11'h5A3;
    @(negedge clk); insn_done = 0;
    chk("R6", busy, 1);
    @(negedge clk); chk("R6", busy, 1);
    @(negedge clk); chk("R6", busy, 1);
    @(negedge clk); chk("R6", busy, 0);
    repeat (2) @(negedge clk);

    // R7: blocked; location-0 completion unblocks but does not enter
    boundary(11'h010, 11'h044);
    chk("R7", busy, 0);
    boundary(11'h000, 11'h5A3);
    chk("R7", busy, 0);
    push_entry(11'h123);
    boundary(11'h5A3, 11'h123);

    // R2: only unmasked latch bits count
    boundary(11'h000, 11'h123);
    set_mask(8'h81);
    latch = 8'h02;
    boundary(11'h123, 11'h124);
    chk("R2", busy, 0);
    latch = 8'h80;
    push_entry(11'h7FF);
    boundary(11'h124, 11'h7FF);

    // R4 R5: all-zero return word
    boundary(11'h000, 11'h7FF);
    push_entry(11'h000);
    boundary(11'h7FF, 11'h000);
    chk("R9", exp_q.size(), 0);

    // R8: parity checker
    latch = 8'h00;
    rd(9'h100);
    chk("R8", perr, 0);
    rd(9'h007);
    chk("R8", perr, 0);
    rd(9'h003);
    chk("R8", perr, 1);
    rd(9'h007);
    chk("R8", perr, 1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule